// File: doc/BRIEF.md
# Justified Four-Tributary Frame Multiplexer

This block assembles a serial higher-order frame out of four lower-rate tributaries, using positive justification. A frame is four sets of equal length, sent in the order set 1, set 2, set 3, set 4 and then repeated. The parameter `SET_BITS` gives the set length: 212 for the second-order level or 384 for the third-order level. One frame bit leaves the block on every clock in which `line_en` is high. In the same clock the block pulses the read strobe of the tributary whose bit is being sent, so that an upstream buffer can supply the next bit.

Set 1 opens with a 10-bit alignment word, a remote-alarm bit and a national-use bit. Sets 2, 3 and 4 each open with four justification control bits, one for each tributary. For every tributary, a stuff request is sampled once per frame. It is repeated in all three control bits, and it decides whether that tributary's slot in set 4 carries data or a dummy zero. Every other bit position carries tributary data, taken one bit at a time in round-robin order.

The control is a four-state set sequencer with the states `ST_SET1`, `ST_SET2`, `ST_SET3` and `ST_SET4`. A bit counter runs within each set. On the last enabled bit of a set the sequencer steps from `ST_SET1` to `ST_SET2`, from `ST_SET2` to `ST_SET3`, from `ST_SET3` to `ST_SET4`, and from `ST_SET4` back to `ST_SET1`. While `line_en` is low it holds. A slot decoder maps (set, position) to one of six slot kinds: align, RAI, national, control, stuff or data. An output process then drives the frame bit and the strobes for that slot.

Top module: `quad_just_mux`

## Requirements
- R1: A frame is exactly 4*SET_BITS enabled clocks long. `frame_start` is high only in the enabled clock that carries bit 0 of set 1.
- R2: Bits 0..9 of set 1 carry the word 1111010000, leftmost bit first. Bit 10 carries `rai_bit` and bit 11 carries `nat_bit`, both as applied in that clock. No read strobe is raised in these 12 positions.
- R3: Bits 12 to the end of set 1 carry tributary data. The tributary served at position p is p mod 4, where index 0 (`trib_data[0]`, `trib_rd[0]`) is tributary 1.
- R4: Bits 0..3 of sets 2, 3 and 4 carry the stuff flag of tributaries index 0..3 in that order, with 1 meaning stuffed. No read strobe is raised in these positions.
- R5: `stuff_req` is sampled in the enabled clock of bit 0 of set 1 and held for the whole frame. Changes at any other time have no effect on that frame's control or stuff bits.
- R6: Bits 4..7 of set 4 are the stuff slots of tributaries index 0..3. An unstuffed tributary sends a data bit there and its strobe pulses. A stuffed tributary sends 0 there and its strobe stays low.
- R7: All other bits of sets 2, 3 and 4 carry data from tributary p mod 4, with its strobe pulsing.
- R8: At most one strobe is high in any clock, and only together with a data bit taken from that tributary. Per frame, each tributary is read ((SET_BITS-12) + 2*(SET_BITS-4) + (SET_BITS-8))/4 times, plus one more if it is unstuffed. While `line_en` is low, `frame_bit`, `frame_start` and `trib_rd` are 0 and the frame position holds.
- R9: Reset (active low, asynchronous) returns the block to bit 0 of set 1, from any point in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | One frame bit is produced in each clock where this is high |
| trib_data | input | 4 | Current data bit of each tributary (index 0 = tributary 1) |
| stuff_req | input | 4 | Per-tributary justification request, sampled at frame start |
| rai_bit | input | 1 | Value of the remote-alarm bit in set 1 |
| nat_bit | input | 1 | Value of the national-use bit in set 1 |
| frame_bit | output | 1 | Serial frame bit for the current enabled clock |
| frame_start | output | 1 | High with the first bit of set 1 |
| trib_rd | output | 4 | Per-tributary read strobe, high when that tributary's bit is taken |

## Verification
Two functions can fall in the same enabled clock: sampling a new stuff request and sending the first alignment bit, because both happen at bit 0 of set 1. The bench provokes this by changing `stuff_req` in exactly that clock after the previous frame has driven the opposite value. It also flips the request again one bit later. It judges the result by comparing every control bit in sets 2 to 4, and the set-4 stuff slots, against the value present at the frame-start clock only. Disabled clocks placed just before frame start confirm that the sampling and `frame_start` wait for an enabled clock.

// File: rtl/jfm_pkg.sv
package jfm_pkg;

    localparam int N_TRIB    = 4;
    localparam int TRIB_W    = 2;
    localparam int ALIGN_LEN = 10;
    localparam int HDR1_LEN  = 12;
    localparam int CTRL_LEN  = 4;
    localparam int STUFF_END = 8;

    typedef enum logic [1:0] {
        ST_SET1,
        ST_SET2,
        ST_SET3,
        ST_SET4
    } set_e;

    typedef enum logic [2:0] {
        SL_ALIGN,
        SL_RAI,
        SL_NAT,
        SL_CTRL,
        SL_STUFF,
        SL_DATA
    } slot_e;

endpackage

// File: rtl/jfm_sequencer.sv
module jfm_sequencer
    import jfm_pkg::*;
#(
    parameter int SET_BITS = 212,
    localparam int POS_W   = $clog2(SET_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output set_e             cur_set,
    output logic [POS_W-1:0] pos,
    output logic             frame_first
);

    set_e             state_q;
    set_e             state_d;
    logic [POS_W-1:0] pos_q;
    logic             set_end;

    assign set_end = (pos_q == POS_W'(SET_BITS - 1));

    // next set in transmission order
    always_comb begin
        unique case (state_q)
            ST_SET1: state_d = ST_SET2;
            ST_SET2: state_d = ST_SET3;
            ST_SET3: state_d = ST_SET4;
            ST_SET4: state_d = ST_SET1;
        endcase
    end

    // state register: advances only on the last enabled bit of a set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SET1;
        end else if (step && set_end) begin
            state_q <= state_d;
        end
    end

    // bit position inside the current set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= set_end ? '0 : pos_q + 1'b1;
        end
    end

    assign cur_set     = state_q;
    assign pos         = pos_q;
    assign frame_first = (state_q == ST_SET1) && (pos_q == '0);

endmodule

// File: rtl/jfm_slot_decode.sv
module jfm_slot_decode
    import jfm_pkg::*;
#(
    parameter int SET_BITS = 212,
    localparam int POS_W   = $clog2(SET_BITS)
) (
    input  set_e              cur_set,
    input  logic [POS_W-1:0]  pos,
    output slot_e             slot,
    output logic [TRIB_W-1:0] trib,
    output logic [3:0]        align_idx
);

    // every field boundary is a multiple of 4, so the tributary is pos mod 4
    assign trib      = pos[TRIB_W-1:0];
    assign align_idx = 4'(ALIGN_LEN - 1) - pos[3:0];

    always_comb begin
        unique case (cur_set)
            ST_SET1: begin
                if (pos < POS_W'(ALIGN_LEN))         slot = SL_ALIGN;
                else if (pos == POS_W'(ALIGN_LEN))   slot = SL_RAI;
                else if (pos < POS_W'(HDR1_LEN))     slot = SL_NAT;
                else                                 slot = SL_DATA;
            end
            ST_SET2, ST_SET3: begin
                if (pos < POS_W'(CTRL_LEN))          slot = SL_CTRL;
                else                                 slot = SL_DATA;
            end
            ST_SET4: begin
                if (pos < POS_W'(CTRL_LEN))          slot = SL_CTRL;
                else if (pos < POS_W'(STUFF_END))    slot = SL_STUFF;
                else                                 slot = SL_DATA;
            end
        endcase
    end

endmodule

// File: rtl/jfm_stuff_hold.sv
module jfm_stuff_hold
    import jfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [N_TRIB-1:0] req,
    output logic [N_TRIB-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= req;
        end
    end

endmodule

// File: rtl/jfm_bit_mux.sv
module jfm_bit_mux
    import jfm_pkg::*;
#(
    parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000
) (
    input  logic              line_en,
    input  slot_e             slot,
    input  logic [TRIB_W-1:0] trib,
    input  logic [3:0]        align_idx,
    input  logic [N_TRIB-1:0] held,
    input  logic [N_TRIB-1:0] trib_data,
    input  logic              rai_bit,
    input  logic              nat_bit,
    output logic              frame_bit,
    output logic [N_TRIB-1:0] trib_rd
);

    always_comb begin
        frame_bit = 1'b0;
        trib_rd   = '0;
        if (line_en) begin
            unique case (slot)
                SL_ALIGN: frame_bit = ALIGN_WORD[align_idx];
                SL_RAI:   frame_bit = rai_bit;
                SL_NAT:   frame_bit = nat_bit;
                SL_CTRL:  frame_bit = held[trib];
                SL_STUFF: begin
                    if (!held[trib]) begin
                        frame_bit = trib_data[trib];
                        trib_rd   = N_TRIB'(1) << trib;
                    end
                end
                SL_DATA: begin
                    frame_bit = trib_data[trib];
                    trib_rd   = N_TRIB'(1) << trib;
                end
                default: begin
                    frame_bit = 1'b0;
                    trib_rd   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/quad_just_mux.sv
module quad_just_mux
    import jfm_pkg::*;
#(
    parameter int SET_BITS                     = 212,
    parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000,
    localparam int POS_W                       = $clog2(SET_BITS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_en,
    input  logic [3:0] trib_data,
    input  logic [3:0] stuff_req,
    input  logic       rai_bit,
    input  logic       nat_bit,
    output logic       frame_bit,
    output logic       frame_start,
    output logic [3:0] trib_rd
);

    set_e              cur_set;
    logic [POS_W-1:0]  pos;
    logic              frame_first;
    slot_e             slot;
    logic [TRIB_W-1:0] trib;
    logic [3:0]        align_idx;
    logic [N_TRIB-1:0] held;

    jfm_sequencer #(.SET_BITS(SET_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (line_en),
        .cur_set     (cur_set),
        .pos         (pos),
        .frame_first (frame_first)
    );

    jfm_slot_decode #(.SET_BITS(SET_BITS)) u_dec (
        .cur_set   (cur_set),
        .pos       (pos),
        .slot      (slot),
        .trib      (trib),
        .align_idx (align_idx)
    );

    jfm_stuff_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (line_en && frame_first),
        .req     (stuff_req),
        .held    (held)
    );

    jfm_bit_mux #(.ALIGN_WORD(ALIGN_WORD)) u_mux (
        .line_en   (line_en),
        .slot      (slot),
        .trib      (trib),
        .align_idx (align_idx),
        .held      (held),
        .trib_data (trib_data),
        .rai_bit   (rai_bit),
        .nat_bit   (nat_bit),
        .frame_bit (frame_bit),
        .trib_rd   (trib_rd)
    );

    assign frame_start = line_en && frame_first;

endmodule

// File: rtl/quad_just_mux_chk.sv
module quad_just_mux_chk #(
    parameter int SET_BITS           = 212,
    parameter logic [9:0] ALIGN_WORD = 10'b1111010000,
    localparam int FRAME_BITS        = 4 * SET_BITS,
    localparam int FW                = $clog2(FRAME_BITS)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_en,
    input logic [3:0] trib_data,
    input logic [3:0] stuff_req,
    input logic       rai_bit,
    input logic       nat_bit,
    input logic       frame_bit,
    input logic       frame_start,
    input logic [3:0] trib_rd
);

    logic [FW-1:0] fcnt;
    logic [3:0]    lat;
    int            cset;
    int            cpos;
    logic [1:0]    ctrib;
    logic [3:0]    fidx;

    // independent count of enabled bits since reset, modulo one frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
            lat  <= '0;
        end else if (line_en) begin
            fcnt <= (fcnt == FW'(FRAME_BITS - 1)) ? '0 : fcnt + 1'b1;
            if (fcnt == '0) lat <= stuff_req;
        end
    end

    always_comb begin
        cset  = int'(fcnt) / SET_BITS;
        cpos  = int'(fcnt) % SET_BITS;
        ctrib = 2'(cpos % 4);
        fidx  = 4'(9 - cpos);
    end

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        line_en |-> (frame_start == (fcnt == '0))); // R1
    AST_ALIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && cset == 0 && cpos < 10) |-> (frame_bit == ALIGN_WORD[fidx])); // R2
    AST_HDR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && cset == 0 && cpos < 12) |-> (trib_rd == 4'b0000)); // R2
    AST_CTRL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && cset != 0 && cpos < 4) |-> (frame_bit == lat[ctrib] && trib_rd == 4'b0000)); // R4
    AST_STUFF_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && cset == 3 && cpos >= 4 && cpos < 8 && lat[ctrib]) |-> (!frame_bit && trib_rd == 4'b0000)); // R6
    AST_RD_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (trib_rd != 4'b0000) |-> (trib_rd[ctrib] && frame_bit == trib_data[ctrib])); // R7
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_rd)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |-> (!frame_start && !frame_bit && trib_rd == 4'b0000)); // R8

endmodule

bind quad_just_mux quad_just_mux_chk #(
    .SET_BITS   (SET_BITS),
    .ALIGN_WORD (ALIGN_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_en     (line_en),
    .trib_data   (trib_data),
    .stuff_req   (stuff_req),
    .rai_bit     (rai_bit),
    .nat_bit     (nat_bit),
    .frame_bit   (frame_bit),
    .frame_start (frame_start),
    .trib_rd     (trib_rd)
);

// File: tb/quad_just_mux_test.sv
module quad_just_mux_test;

    localparam int CLK_PERIOD = 10;
    localparam int SB         = 212;
    localparam int FRAME      = 4 * SB;
    localparam logic [9:0] AW = 10'b1111010000;
    localparam int BASE_RD    = ((SB - 12) + 2 * (SB - 4) + (SB - 8)) / 4;
    localparam int NVEC       = 6;

    // {stuff[3:0], flip, seed[7:0], rai, nat, gap[3:0]}
    localparam logic [18:0] VECS [NVEC] = '{
        {4'b0000, 1'b0, 8'd1, 1'b0, 1'b1, 4'd0},
        {4'b1111, 1'b0, 8'd2, 1'b1, 1'b0, 4'd0},
        {4'b1010, 1'b1, 8'd3, 1'b1, 1'b1, 4'd3},
        {4'b0101, 1'b1, 8'd4, 1'b0, 1'b0, 4'd0},
        {4'b0011, 1'b0, 8'd5, 1'b1, 1'b0, 4'd5},
        {4'b1100, 1'b1, 8'd6, 1'b0, 1'b1, 4'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_en;
    logic [3:0] trib_data;
    logic [3:0] stuff_req;
    logic       rai_bit;
    logic       nat_bit;
    logic       frame_bit;
    logic       frame_start;
    logic [3:0] trib_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    quad_just_mux #(.SET_BITS(SB)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_en     (line_en),
        .trib_data   (trib_data),
        .stuff_req   (stuff_req),
        .rai_bit     (rai_bit),
        .nat_bit     (nat_bit),
        .frame_bit   (frame_bit),
        .frame_start (frame_start),
        .trib_rd     (trib_rd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int f, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s bit=%0d actual=%0h expected=%0h", tag, f, act, exp);
        end
    endtask

    function automatic logic gen_bit(input int seed, input int k, input int c);
        int v;
        v = c * 37 + k * 11 + seed * 5;
        return v[3] ^ v[0] ^ v[6];
    endfunction

    task automatic idle_cycle(input int f);
        @(negedge clk);
        line_en   = 1'b0;
        trib_data = ~trib_data;
        #1;
        check(frame_bit == 1'b0 && trib_rd == 4'b0 && frame_start == 1'b0,
              "R8 idle", f, {frame_start, trib_rd, frame_bit}, 0);
    endtask

    task automatic run_frame(input logic [3:0] stf, input bit flip, input int seed,
                             input logic r, input logic n, input int gap, input int limit);
        int dcnt [4];
        int rdc  [4];
        for (int k = 0; k < 4; k++) begin
            dcnt[k] = 0;
            rdc[k]  = 0;
        end
        for (int f = 0; f < limit; f++) begin
            int         st;
            int         ps;
            int         tr;
            logic       eb;
            logic [3:0] er;
            logic       es;
            string      tg;
            st = f / SB;
            ps = f % SB;
            tr = ps % 4;
            if (gap > 0 && f % gap == 0) idle_cycle(f);
            @(negedge clk);
            line_en   = 1'b1;
            rai_bit   = r;
            nat_bit   = n;
            stuff_req = (f == 0 || !flip) ? stf : ~stf;
            for (int k = 0; k < 4; k++) trib_data[k] = gen_bit(seed, k, dcnt[k]);
            eb = 1'b0;
            er = 4'b0;
            es = (f == 0);
            if (st == 0) begin
                if (ps < 10) begin
                    eb = AW[9 - ps];
                    tg = (ps == 0) ? "R1/R9 start R2 align" : "R2 align";
                end else if (ps == 10) begin
                    eb = r;
                    tg = "R2 rai";
                end else if (ps == 11) begin
                    eb = n;
                    tg = "R2 nat";
                end else begin
                    eb = trib_data[tr];
                    er[tr] = 1'b1;
                    tg = "R3 set1 data";
                end
            end else if (ps < 4) begin
                eb = stf[tr];
                tg = flip ? "R5 held ctrl" : "R4 ctrl";
            end else if (st == 3 && ps < 8) begin
                tg = flip ? "R5/R6 stuff" : "R6 stuff";
                if (!stf[tr]) begin
                    eb = trib_data[tr];
                    er[tr] = 1'b1;
                end
            end else begin
                eb = trib_data[tr];
                er[tr] = 1'b1;
                tg = "R7 data";
            end
            if (er != 4'b0) dcnt[tr]++;
            #1;
            check(frame_bit == eb && trib_rd == er && frame_start == es, tg, f,
                  {frame_start, trib_rd, frame_bit}, {es, er, eb});
            for (int k = 0; k < 4; k++) rdc[k] += int'(trib_rd[k]);
        end
        if (limit == FRAME) begin
            for (int k = 0; k < 4; k++) begin
                check(rdc[k] == BASE_RD + (stf[k] ? 0 : 1), "R8 reads per frame", k,
                      rdc[k], BASE_RD + (stf[k] ? 0 : 1));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        line_en   = 1'b0;
        trib_data = 4'b0;
        stuff_req = 4'b0;
        rai_bit   = 1'b0;
        nat_bit   = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(frame_bit == 1'b0 && frame_start == 1'b0 && trib_rd == 4'b0,
              "R9 reset outputs", 0, {frame_start, trib_rd, frame_bit}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // partial frame, then reset mid-frame: next frame must start over (R9)
        run_frame(4'b0110, 1'b0, 9, 1'b1, 1'b1, 0, 2 * SB + 30);
        @(negedge clk);
        line_en = 1'b0;
        rst_n   = 1'b0;
        #1;
        check(frame_bit == 1'b0 && frame_start == 1'b0 && trib_rd == 4'b0,
              "R9 mid-frame reset", 0, {frame_start, trib_rd, frame_bit}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // vector table: one full frame per entry
        for (int i = 0; i < NVEC; i++) begin
            logic [18:0] v;
            v = VECS[i];
            run_frame(v[18:15], v[14], int'(v[13:6]), v[5], v[4], int'(v[3:0]), FRAME);
        end

        // directed: disabled clocks around the frame start hold the position (R1, R8)
        idle_cycle(0);
        idle_cycle(0);
        run_frame(4'b1001, 1'b1, 11, 1'b1, 1'b0, 7, FRAME);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule